// File: doc/BRIEF.md
# Task Switch Permission Checker

This block decides whether a requested switch to another task may go ahead. The requester gives the kind of transfer (jump, call, software interrupt, hardware interrupt, exception or return) and the current privilege level. It also gives the requested privilege level carried by the selector, and says whether the target was reached through a task gate. When a gate was used, both words of the gate are supplied as well. The remaining inputs are the two words of the target task-state descriptor, as already fetched, and the limit of the global descriptor table.

The block runs five checks in a fixed order and reports only the first one that fails. The order is selector range and table, then privilege, then presence, then busy state, then descriptor limit. A result is either pass or one fault class: general protection, not present or invalid task state. It comes with the target selector to use as the error code. The work is pipelined across three register stages, so a new request can enter on every cycle and results leave in request order. Fetching descriptors from memory and saving task state are the job of other blocks.

Top module: `task_switch_guard`

## Requirements
- R1: The target selector is `gate_lo[31:16]` when `via_gate` is 1 and `tss_sel` otherwise. A general-protection fault is raised if its table-indicator bit 2 is 1, or if its last byte (`{sel[15:3],3'b111}`) lies above `gdt_limit`.
- R2: A jump (`req_kind`=0) or call (1) raises a general-protection fault if either `cur_pl` or `sel_rpl` is numerically greater than the referenced DPL.
- R3: When `via_gate` is 1, the referenced DPL is the gate's DPL (`gate_hi[14:13]`) and the descriptor's DPL (`desc_hi[14:13]`) has no effect. The two low bits of the gate's selector do not enter any check.
- R4: A hardware interrupt (3), exception (4) or return (5) passes the privilege check regardless of levels. A software interrupt (2) faults with general protection only when `cur_pl` exceeds the referenced DPL, and `sel_rpl` is ignored for it.
- R5: A descriptor whose present bit `desc_hi[15]` is 0 yields a not-present fault.
- R6: Busy is `desc_hi[9]`. A busy target yields a general-protection fault for every kind except return. A return whose target is not busy yields an invalid-task-state fault.
- R7: The descriptor limit is `{desc_hi[19:16],desc_lo[15:0]}`. When granularity bit `desc_hi[23]` is 1 it is scaled by 4096 with the low 12 bits filled with ones. An effective limit below 0x67 yields an invalid-task-state fault.
- R8: When several checks fail, only the first is reported, in the order R1, privilege (R2 to R4), R5, R6, R7.
- R9: `rsp_fault` encodes 0 pass, 1 general protection, 2 not present, 3 invalid task state. On a fault `rsp_errsel` is the target selector with bits 1:0 cleared. On pass it is 0.
- R10: Each request sampled with `req_valid` high produces exactly one `rsp_valid` pulse three clock edges later. Requests may arrive on consecutive cycles.
- R11: During and right after reset `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Transfer kind, encoded as in R2 and R4 |
| cur_pl | input | 2 | Current privilege level |
| sel_rpl | input | 2 | Requested privilege level of the referencing selector |
| via_gate | input | 1 | Target reached through a task gate |
| gate_lo | input | 32 | Gate low word, target selector in bits 31:16 |
| gate_hi | input | 32 | Gate high word, DPL in bits 14:13 |
| tss_sel | input | 16 | Direct target selector when no gate is used |
| desc_lo | input | 32 | Task-state descriptor low word |
| desc_hi | input | 32 | Task-state descriptor high word |
| gdt_limit | input | 16 | Global descriptor table limit in bytes |
| rsp_valid | output | 1 | Result present |
| rsp_fault | output | 2 | Fault class per R9 |
| rsp_errsel | output | 16 | Selector to report as error code |

## Verification
The hardest situation to reach is a single request that breaks several rules at once, because only the ordering decides what is reported. The bench builds descriptors field by field, so it can stack a privilege violation on a missing descriptor, or a busy target on a short limit, and then check that only the earliest rule wins. A second subtle case is a gate whose own DPL permits the switch while the descriptor's DPL would forbid it. Here the bench also sets the gate selector's low bits, so that the reported error code shows those bits were dropped.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

  localparam int SEL_W = 16;
  localparam int LIM_W = 16;
  localparam int WORD_W = 32;
  localparam logic [31:0] MIN_TSS_LIMIT = 32'h0000_0067;

  typedef enum logic [2:0] {
    K_JUMP  = 3'd0,
    K_CALL  = 3'd1,
    K_SWINT = 3'd2,
    K_HWINT = 3'd3,
    K_EXC   = 3'd4,
    K_RET   = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    F_PASS = 2'd0,
    F_GP   = 2'd1,
    F_NP   = 2'd2,
    F_TS   = 2'd3
  } fault_e;

  typedef struct packed {
    kind_e              kind;
    logic [1:0]         cpl;
    logic [1:0]         rpl;
    logic               via_gate;
    logic [WORD_W-1:0]  gate_lo;
    logic [WORD_W-1:0]  gate_hi;
    logic [SEL_W-1:0]   sel;
    logic [WORD_W-1:0]  desc_lo;
    logic [WORD_W-1:0]  desc_hi;
    logic [LIM_W-1:0]   gdt_limit;
  } req_t;

  typedef struct packed {
    kind_e            kind;
    logic             range_f;
    logic             priv_f;
    logic             np_f;
    logic             busy_f;
    fault_e           busy_cls;
    logic             lim_f;
    logic [SEL_W-1:0] sel;
  } flags_t;

  // Effective descriptor limit with granularity scaling.
  function automatic logic [31:0] eff_limit(input logic [WORD_W-1:0] lo,
                                            input logic [WORD_W-1:0] hi);
    logic [19:0] raw;
    raw = {hi[19:16], lo[15:0]};
    return hi[23] ? {raw, 12'hFFF} : {12'h000, raw};
  endfunction

  // Privilege verdict per request kind: 1 means violation.
  function automatic logic priv_violation(input kind_e k, input logic [1:0] cpl,
                                          input logic [1:0] rpl, input logic [1:0] dpl);
    case (k)
      K_JUMP, K_CALL: return (cpl > dpl) || (rpl > dpl);
      K_SWINT:        return (cpl > dpl);
      default:        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tsg_decode.sv
module tsg_decode
  import tsg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   vin,
  input  req_t   rq,
  output logic   vout,
  output flags_t fl
);

  logic [SEL_W-1:0] tgt_sel;
  logic [1:0]       ref_dpl;
  logic             is_busy;
  flags_t           nx;

  always_comb begin
    tgt_sel     = rq.via_gate ? rq.gate_lo[31:16] : rq.sel;
    ref_dpl     = rq.via_gate ? rq.gate_hi[14:13] : rq.desc_hi[14:13];
    is_busy     = rq.desc_hi[9];
    nx.kind     = rq.kind;
    nx.sel      = {tgt_sel[SEL_W-1:2], 2'b00};
    nx.range_f  = tgt_sel[2] || ({tgt_sel[SEL_W-1:3], 3'b111} > rq.gdt_limit);
    nx.priv_f   = priv_violation(rq.kind, rq.cpl, rq.rpl, ref_dpl);
    nx.np_f     = !rq.desc_hi[15];
    nx.busy_f   = (rq.kind == K_RET) ? !is_busy : is_busy;
    nx.busy_cls = (rq.kind == K_RET) ? F_TS : F_GP;
    nx.lim_f    = eff_limit(rq.desc_lo, rq.desc_hi) < MIN_TSS_LIMIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vout <= 1'b0;
      fl   <= '0;
    end else begin
      vout <= vin;
      if (vin) fl <= nx;
    end
  end

  // R4: exempt kinds never carry a privilege failure
  a_r4_exempt_no_priv: assert property (@(posedge clk) disable iff (!rst_n)
    vout && (fl.kind inside {K_HWINT, K_EXC, K_RET}) |-> !fl.priv_f);

  // R9: reported selector never keeps its requested-level bits
  a_r9_sel_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    vout |-> fl.sel[1:0] == 2'b00);

endmodule

// File: rtl/tsg_prio.sv
module tsg_prio
  import tsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vin,
  input  flags_t           fl,
  output logic             vout,
  output fault_e           fault,
  output logic [SEL_W-1:0] errsel
);

  fault_e first_fail;

  always_comb begin
    if (fl.range_f)     first_fail = F_GP;
    else if (fl.priv_f) first_fail = F_GP;
    else if (fl.np_f)   first_fail = F_NP;
    else if (fl.busy_f) first_fail = fl.busy_cls;
    else if (fl.lim_f)  first_fail = F_TS;
    else                first_fail = F_PASS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vout   <= 1'b0;
      fault  <= F_PASS;
      errsel <= '0;
    end else begin
      vout <= vin;
      if (vin) begin
        fault  <= first_fail;
        errsel <= (first_fail == F_PASS) ? '0 : fl.sel;
      end
    end
  end

  // R8: a range failure always wins
  a_r8_range_first: assert property (@(posedge clk) disable iff (!rst_n)
    vin && fl.range_f |=> fault == F_GP);

  // R5: absence reported when the earlier checks are clean
  a_r5_np_reported: assert property (@(posedge clk) disable iff (!rst_n)
    vin && !fl.range_f && !fl.priv_f && fl.np_f |=> fault == F_NP);

  // R9: pass carries a zero error selector
  a_r9_pass_zero: assert property (@(posedge clk) disable iff (!rst_n)
    vout && fault == F_PASS |-> errsel == '0);

endmodule

// File: rtl/task_switch_guard.sv
module task_switch_guard
  import tsg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_kind,
  input  logic [1:0]  cur_pl,
  input  logic [1:0]  sel_rpl,
  input  logic        via_gate,
  input  logic [31:0] gate_lo,
  input  logic [31:0] gate_hi,
  input  logic [15:0] tss_sel,
  input  logic [31:0] desc_lo,
  input  logic [31:0] desc_hi,
  input  logic [15:0] gdt_limit,
  output logic        rsp_valid,
  output logic [1:0]  rsp_fault,
  output logic [15:0] rsp_errsel
);

  req_t   s1_rq;
  logic   s1_v;
  logic   s2_v;
  flags_t s2_fl;
  fault_e s3_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_rq <= '0;
    end else begin
      s1_v <= req_valid;
      if (req_valid) begin
        s1_rq.kind      <= kind_e'(req_kind);
        s1_rq.cpl       <= cur_pl;
        s1_rq.rpl       <= sel_rpl;
        s1_rq.via_gate  <= via_gate;
        s1_rq.gate_lo   <= gate_lo;
        s1_rq.gate_hi   <= gate_hi;
        s1_rq.sel       <= tss_sel;
        s1_rq.desc_lo   <= desc_lo;
        s1_rq.desc_hi   <= desc_hi;
        s1_rq.gdt_limit <= gdt_limit;
      end
    end
  end

  tsg_decode u_decode (
    .clk   (clk),
    .rst_n (rst_n),
    .vin   (s1_v),
    .rq    (s1_rq),
    .vout  (s2_v),
    .fl    (s2_fl)
  );

  tsg_prio u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .vin    (s2_v),
    .fl     (s2_fl),
    .vout   (rsp_valid),
    .fault  (s3_fault),
    .errsel (rsp_errsel)
  );

  assign rsp_fault = s3_fault;

  // R10: one result per request, three edges later
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid, 3));

  // R11: nothing valid in the cycle after reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);

endmodule

// File: tb/test_task_switch_guard.sv
module test_task_switch_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [1:0]  cur_pl = '0;
  logic [1:0]  sel_rpl = '0;
  logic        via_gate = 1'b0;
  logic [31:0] gate_lo = '0;
  logic [31:0] gate_hi = '0;
  logic [15:0] tss_sel = '0;
  logic [31:0] desc_lo = '0;
  logic [31:0] desc_hi = '0;
  logic [15:0] gdt_limit = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [15:0] rsp_errsel;

  int checks = 0;
  int failures = 0;
  logic [17:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  task_switch_guard i_task_switch_guard (.*);

  // Independent reference: returns {fault, errsel}
  function automatic logic [17:0] model(int kind, int cpl, int rpl, bit gate,
      int gdpl, logic [15:0] gsel, logic [15:0] dsel, bit p, bit b, int dpl,
      int lim, bit g, int gdtlim);
    logic [15:0] s;
    int d;
    int last_byte;
    longint eff;
    bit bad;
    s = gate ? gsel : dsel;
    d = gate ? gdpl : dpl;
    last_byte = int'(s[15:3]) * 8 + 7;
    eff = g ? (longint'(lim) * 4096 + 4095) : longint'(lim);
    bad = 0;
    if (kind <= 1) bad = (cpl > d) || (rpl > d);
    if (kind == 2) bad = (cpl > d);
    if (s[2] == 1'b1 || last_byte > gdtlim) return {2'd1, s[15:2], 2'b00};
    if (bad) return {2'd1, s[15:2], 2'b00};
    if (!p) return {2'd2, s[15:2], 2'b00};
    if (kind == 5 && !b) return {2'd3, s[15:2], 2'b00};
    if (kind != 5 && b) return {2'd1, s[15:2], 2'b00};
    if (eff < 103) return {2'd3, s[15:2], 2'b00};
    return 18'd0;
  endfunction

  task automatic send(string tag, int kind, int cpl, int rpl, bit gate, int gdpl,
      logic [15:0] gsel, logic [15:0] dsel, bit p, bit b, int dpl, int lim, bit g,
      int gdtlim);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 3'(kind);
    cur_pl    = 2'(cpl);
    sel_rpl   = 2'(rpl);
    via_gate  = gate;
    gate_lo   = {gsel, 16'h0000};
    gate_hi   = {16'h0000, 1'b1, 2'(gdpl), 5'b00101, 8'h00};
    tss_sel   = dsel;
    desc_lo   = {16'h0000, 16'(lim)};
    desc_hi   = {8'h00, g, 3'b000, 4'(lim >> 16), p, 2'(dpl), 1'b0, 1'b1, 1'b0, b, 1'b1, 8'h00};
    gdt_limit = 16'(gdtlim);
    exp_q.push_back(model(kind, cpl, rpl, gate, gdpl, gsel, dsel, p, b, dpl, lim, g, gdtlim));
    tag_q.push_back(tag);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R10 unexpected result fault=%0d sel=%h expected none", rsp_fault, rsp_errsel);
      end else begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_fault, rsp_errsel} !== e) begin
          failures++;
          $display("FAIL %s fault=%0d sel=%h expected fault=%0d sel=%h",
                   t, rsp_fault, rsp_errsel, e[17:16], e[15:0]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R11 rsp_valid=%b expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R11 after reset rsp_valid=%b expected 0", rsp_valid);
    end
    // kind: 0 jump 1 call 2 swint 3 hwint 4 exc 5 ret
    send("R9 jump pass",            0, 0, 0, 0, 0, 16'h0, 16'h0028, 1, 0, 3, 16'h67, 0, 16'hFF);
    send("R1 table bit set",        0, 0, 0, 0, 0, 16'h0, 16'h002C, 1, 0, 3, 16'h67, 0, 16'hFF);
    send("R1 beyond table",         0, 0, 0, 0, 0, 16'h0, 16'h0100, 1, 0, 3, 16'h67, 0, 16'hFF);
    send("R1 last entry fits",      0, 0, 0, 0, 0, 16'h0, 16'h00F8, 1, 0, 3, 16'h67, 0, 16'hFF);
    send("R2 call cpl above dpl",   1, 3, 0, 0, 0, 16'h0, 16'h0028, 1, 0, 2, 16'h67, 0, 16'hFF);
    send("R2 call rpl above dpl",   1, 0, 3, 0, 0, 16'h0, 16'h0028, 1, 0, 2, 16'h67, 0, 16'hFF);
    send("R3 gate dpl permits",     1, 3, 3, 1, 3, 16'h0033, 16'h0, 1, 0, 0, 16'h67, 0, 16'hFF);
    send("R3 gate sel rpl dropped", 0, 0, 0, 1, 3, 16'h0033, 16'h0, 1, 1, 0, 16'h67, 0, 16'hFF);
    send("R3 gate dpl forbids",     1, 3, 0, 1, 0, 16'h0030, 16'h0, 1, 0, 3, 16'h67, 0, 16'hFF);
    send("R4 hwint exempt",         3, 3, 3, 1, 0, 16'h0030, 16'h0, 1, 0, 0, 16'h67, 0, 16'hFF);
    send("R4 exception exempt",     4, 3, 3, 1, 0, 16'h0030, 16'h0, 1, 0, 0, 16'h67, 0, 16'hFF);
    send("R4 swint cpl checked",    2, 3, 0, 1, 0, 16'h0030, 16'h0, 1, 0, 3, 16'h67, 0, 16'hFF);
    send("R4 swint rpl ignored",    2, 0, 3, 1, 0, 16'h0030, 16'h0, 1, 0, 3, 16'h67, 0, 16'hFF);
    send("R5 not present",          0, 0, 0, 0, 0, 16'h0, 16'h0040, 0, 0, 3, 16'h67, 0, 16'hFF);
    send("R6 jump busy",            0, 0, 0, 0, 0, 16'h0, 16'h0040, 1, 1, 3, 16'h67, 0, 16'hFF);
    send("R6 return not busy",      5, 3, 3, 0, 0, 16'h0, 16'h0048, 1, 0, 0, 16'h67, 0, 16'hFF);
    send("R6 return busy pass",     5, 3, 3, 0, 0, 16'h0, 16'h0048, 1, 1, 0, 16'h67, 0, 16'hFF);
    send("R7 limit too small",      0, 0, 0, 0, 0, 16'h0, 16'h0050, 1, 0, 3, 16'h66, 0, 16'hFF);
    send("R7 granular limit",       0, 0, 0, 0, 0, 16'h0, 16'h0050, 1, 0, 3, 16'h05, 1, 16'hFF);
    send("R7 limit upper bits",     0, 0, 0, 0, 0, 16'h0, 16'h0050, 1, 0, 3, 32'h10000, 0, 16'hFF);
    send("R8 priv before present",  1, 3, 0, 0, 0, 16'h0, 16'h0058, 0, 1, 0, 16'h10, 0, 16'hFF);
    send("R8 present before busy",  1, 0, 0, 0, 0, 16'h0, 16'h0058, 0, 1, 3, 16'h10, 0, 16'hFF);
    send("R8 busy before limit",    1, 0, 0, 0, 0, 16'h0, 16'h0058, 1, 1, 3, 16'h10, 0, 16'hFF);
    send("R8 range before all",     1, 3, 3, 0, 0, 16'h0, 16'h005C, 0, 1, 0, 16'h10, 0, 16'hFF);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R10 missing results=%0d expected 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule